// File: doc/BRIEF.md
# Burst-of-Two Double-Rate SRAM Controller

This block is the bus master for a synchronous SRAM that moves two data words per clock. A user client hands it read and write requests through a valid/ready pair. For each accepted request the controller drives a single-cycle command to the memory: an active-low load strobe, a direction select and the start address A. Every access is a fixed burst of two words, at A and at A+1. The double-rate data path is modelled inside the block as a two-word bus in one clock domain: a low word for A and a high word for A+1.

For a write, the controller drives both write words onto the bus one cycle after the command. It enables its drivers only in that cycle and leaves the bus released at all other times. For a read, the memory sends its two words back after a latency that depends on whether the memory's delay-locked loop is running. The latency is two cycles normally and one cycle with the loop disabled. The memory also raises a valid-data qualifier with the data.

The controller keeps a small in-order tracker of the reads it has issued. It latches read words only when the qualifier is present and returns them with a response strobe, in issue order. A read whose qualifier never arrives is retired with a sticky timeout flag. The controller inserts idle cycles between writes and reads wherever the write drive would come too close to a read return on the shared bus. `dll_off` must only change while no read is outstanding.

Top module: `b2_sram_ctrl`

## Requirements
- R1: After reset, `mem_ld_n` is 1, `mem_wd_oe` is 0, `rsp_valid` is 0, `err_timeout` is 0, and `req_ready` is 1 for a read request.
- R2: A request is accepted in a cycle with `req_valid` and `req_ready` both high. In that cycle `mem_ld_n` is 0, `mem_addr` equals `req_addr`, and `mem_rw` is 1 for a read and 0 for a write. In every other cycle `mem_ld_n` is 1, which is a no-operation.
- R3: `mem_wd_oe` is 1 exactly in the cycle after a write command. In that cycle `mem_wd_lo` carries the word for A and `mem_wd_hi` carries the word for A+1, both taken from the request. In all other cycles the bus is released (`mem_wd_oe` is 0).
- R4: When the memory answers on time, a read issued in cycle c has its data on the read bus in cycle c+L. L is 2 with `dll_off`=0 and 1 with `dll_off`=1. `rsp_valid` is then high in cycle c+L+1.
- R5: Read words are latched only in a cycle where `mem_qvld` is 1 and a read is outstanding. A `mem_qvld` pulse with no read outstanding produces no response and no error.
- R6: Responses come back in issue order. Each response carries `rsp_addr` equal to A, with `rsp_rdata_lo` holding the word at A and `rsp_rdata_hi` the word at A+1.
- R7: If no qualifier arrives while the oldest read is 1 to L+1 cycles old, that read is retired without a response when it reaches age L+2. `err_timeout` then goes to 1 and stays at 1 until reset.
- R8: A read command follows a write command by at least 2 cycles when `dll_off`=1. With `dll_off`=0 it may follow in the very next cycle.
- R9: A write command follows a read command by at least 3 cycles when `dll_off`=0, and by at least 2 cycles when `dll_off`=1.
- R10: Commands of the same direction are accepted in consecutive cycles.
- R11: At most RD_DEPTH (default 4) reads are outstanding. While the tracker is full, a read request sees `req_ready` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dll_off | input | 1 | 1 selects the one-cycle read latency |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Burst start address A |
| req_wdata_lo | input | DW | Write word for A |
| req_wdata_hi | input | DW | Write word for A+1 |
| mem_ld_n | output | 1 | Command strobe, active low |
| mem_rw | output | 1 | 1 = read, 0 = write |
| mem_addr | output | AW | Command address |
| mem_wd_oe | output | 1 | Write drivers enabled |
| mem_wd_lo | output | DW | Write word for A |
| mem_wd_hi | output | DW | Write word for A+1 |
| mem_qvld | input | 1 | Read-data qualifier from the memory |
| mem_rd_lo | input | DW | Read word for A |
| mem_rd_hi | input | DW | Read word for A+1 |
| rsp_valid | output | 1 | Response strobe |
| rsp_addr | output | AW | Address A of the response |
| rsp_rdata_lo | output | DW | Read word for A |
| rsp_rdata_hi | output | DW | Read word for A+1 |
| err_timeout | output | 1 | Sticky missed-qualifier flag |

## Verification
A wrong turnaround counter appears at the command pins straight away. A write and a read land too close together, or a legal pair is stalled, and either one moves the accept cycle of the second command by a cycle the bench predicts. A wrong tracker pointer or timestamp shows within L+2 cycles of the affected read. The effect is a response at the wrong cycle, a response with another read's address or data, a missing response, or an `err_timeout` set or left clear when it should not be. A wrong write stage shows one cycle after the command, as a driver enable or data word that differs from the request.

// File: rtl/b2_pkg.sv
`timescale 1ns/1ps
package b2_pkg;

  // read latency in cycles for the selected clocking mode
  function automatic int rd_lat(input logic dll_off);
    return dll_off ? 1 : 2;
  endfunction

  // a read may issue once the last write is this many cycles back
  function automatic logic rd_gap_ok(input int since_wr, input logic dll_off);
    return since_wr >= (3 - rd_lat(dll_off));
  endfunction

  // a write may issue once the last read is this many cycles back
  function automatic logic wr_gap_ok(input int since_rd, input logic dll_off);
    return since_rd >= (rd_lat(dll_off) + 1);
  endfunction

  // the qualifier window of a read closes at this age
  function automatic logic window_over(input int age, input logic dll_off);
    return age >= (rd_lat(dll_off) + 2);
  endfunction

  function automatic int sat_step(input int v, input int cap);
    return (v >= cap) ? cap : v + 1;
  endfunction

endpackage

// File: rtl/b2_turnaround.sv
`timescale 1ns/1ps
module b2_turnaround #(
  parameter int GAP_CAP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dll_off,
  input  logic rd_fire,
  input  logic wr_fire,
  output logic rd_ok,
  output logic wr_ok
);
  import b2_pkg::*;

  localparam int GW = $clog2(GAP_CAP + 1);

  logic [GW-1:0] since_rd_q;
  logic [GW-1:0] since_wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rd_q <= GW'(GAP_CAP);
      since_wr_q <= GW'(GAP_CAP);
    end else begin
      since_rd_q <= rd_fire ? GW'(1) : GW'(sat_step(int'(since_rd_q), GAP_CAP));
      since_wr_q <= wr_fire ? GW'(1) : GW'(sat_step(int'(since_wr_q), GAP_CAP));
    end
  end

  assign rd_ok = rd_gap_ok(int'(since_wr_q), dll_off);
  assign wr_ok = wr_gap_ok(int'(since_rd_q), dll_off);

endmodule

// File: rtl/b2_wr_stage.sv
`timescale 1ns/1ps
module b2_wr_stage #(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [DW-1:0] lo_in,
  input  logic [DW-1:0] hi_in,
  output logic          oe,
  output logic [DW-1:0] lo_out,
  output logic [DW-1:0] hi_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe     <= 1'b0;
      lo_out <= '0;
      hi_out <= '0;
    end else begin
      oe     <= fire;
      lo_out <= fire ? lo_in : '0;
      hi_out <= fire ? hi_in : '0;
    end
  end

endmodule

// File: rtl/b2_rd_tracker.sv
`timescale 1ns/1ps
module b2_rd_tracker #(
  parameter int AW    = 20,
  parameter int DW    = 18,
  parameter int DEPTH = 4,
  parameter int TSW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic          push_dll,
  input  logic          qvld,
  input  logic [DW-1:0] rd_lo,
  input  logic [DW-1:0] rd_hi,
  output logic          full,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_addr,
  output logic [DW-1:0] rsp_lo,
  output logic [DW-1:0] rsp_hi,
  output logic          err_timeout,
  output logic          capture,
  output logic          expire
);
  import b2_pkg::*;

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0]  addr_m [DEPTH];
  logic           dll_m  [DEPTH];
  logic [TSW-1:0] ts_m   [DEPTH];
  logic [PW-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]  cnt_q;
  logic [TSW-1:0] cyc_q;
  logic [TSW-1:0] head_age;
  logic           empty;
  logic           pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CW'(DEPTH));
  assign head_age = cyc_q - ts_m[rd_ptr_q];
  assign expire   = !empty && window_over(int'(head_age), dll_m[rd_ptr_q]);
  assign capture  = !empty && !expire && qvld;
  assign pop      = expire || capture;

  always_ff @(posedge clk) begin
    if (push) begin
      addr_m[wr_ptr_q] <= push_addr;
      dll_m[wr_ptr_q]  <= push_dll;
      ts_m[wr_ptr_q]   <= cyc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      cyc_q    <= '0;
    end else begin
      cyc_q <= cyc_q + TSW'(1);
      if (push) wr_ptr_q <= bump(wr_ptr_q);
      if (pop)  rd_ptr_q <= bump(rd_ptr_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_addr    <= '0;
      rsp_lo      <= '0;
      rsp_hi      <= '0;
      err_timeout <= 1'b0;
    end else begin
      rsp_valid <= capture;
      if (capture) begin
        rsp_addr <= addr_m[rd_ptr_q];
        rsp_lo   <= rd_lo;
        rsp_hi   <= rd_hi;
      end
      if (expire) err_timeout <= 1'b1;
    end
  end

endmodule

// File: rtl/b2_sram_ctrl.sv
`timescale 1ns/1ps
module b2_sram_ctrl #(
  parameter int AW       = 20,
  parameter int DW       = 18,
  parameter int RD_DEPTH = 4,
  parameter int TS_W     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dll_off,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata_lo,
  input  logic [DW-1:0] req_wdata_hi,
  output logic          mem_ld_n,
  output logic          mem_rw,
  output logic [AW-1:0] mem_addr,
  output logic          mem_wd_oe,
  output logic [DW-1:0] mem_wd_lo,
  output logic [DW-1:0] mem_wd_hi,
  input  logic          mem_qvld,
  input  logic [DW-1:0] mem_rd_lo,
  input  logic [DW-1:0] mem_rd_hi,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_addr,
  output logic [DW-1:0] rsp_rdata_lo,
  output logic [DW-1:0] rsp_rdata_hi,
  output logic          err_timeout
);

  // named internal events, also watched by the bound checker
  logic rd_ok, wr_ok, rd_full;
  logic rd_fire, wr_fire, any_fire;
  logic rd_capture, rd_expire;

  assign rd_fire   = req_valid && !req_write && rd_ok && !rd_full;
  assign wr_fire   = req_valid &&  req_write && wr_ok;
  assign any_fire  = rd_fire || wr_fire;
  assign req_ready = req_write ? wr_ok : (rd_ok && !rd_full);

  assign mem_ld_n = !any_fire;
  assign mem_rw   = !wr_fire;
  assign mem_addr = any_fire ? req_addr : '0;

  b2_turnaround #(.GAP_CAP(3)) u_turn (
    .clk     (clk),
    .rst_n   (rst_n),
    .dll_off (dll_off),
    .rd_fire (rd_fire),
    .wr_fire (wr_fire),
    .rd_ok   (rd_ok),
    .wr_ok   (wr_ok)
  );

  b2_wr_stage #(.DW(DW)) u_wr (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (wr_fire),
    .lo_in  (req_wdata_lo),
    .hi_in  (req_wdata_hi),
    .oe     (mem_wd_oe),
    .lo_out (mem_wd_lo),
    .hi_out (mem_wd_hi)
  );

  b2_rd_tracker #(.AW(AW), .DW(DW), .DEPTH(RD_DEPTH), .TSW(TS_W)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (rd_fire),
    .push_addr   (req_addr),
    .push_dll    (dll_off),
    .qvld        (mem_qvld),
    .rd_lo       (mem_rd_lo),
    .rd_hi       (mem_rd_hi),
    .full        (rd_full),
    .rsp_valid   (rsp_valid),
    .rsp_addr    (rsp_addr),
    .rsp_lo      (rsp_rdata_lo),
    .rsp_hi      (rsp_rdata_hi),
    .err_timeout (err_timeout),
    .capture     (rd_capture),
    .expire      (rd_expire)
  );

endmodule

// File: rtl/b2_sram_ctrl_chk.sv
`timescale 1ns/1ps
module b2_sram_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic dll_off,
  input logic req_valid,
  input logic req_ready,
  input logic mem_ld_n,
  input logic mem_rw,
  input logic mem_wd_oe,
  input logic mem_qvld,
  input logic rsp_valid,
  input logic err_timeout,
  input logic rd_capture,
  input logic rd_expire
);

  AST_NOP_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |-> mem_ld_n); // R2

  AST_WR_BEATS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ld_n && !mem_rw) |=> mem_wd_oe); // R3

  AST_OE_ONLY_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wd_oe |-> $past(!mem_ld_n && !mem_rw)); // R3

  AST_CAPTURE_TO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |=> rsp_valid); // R4

  AST_RSP_NEEDS_QVLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(mem_qvld)); // R5

  AST_EXPIRE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_expire |=> (err_timeout && !rsp_valid)); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |=> err_timeout); // R7

  AST_RD_AFTER_WR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ld_n && !mem_rw && dll_off) |=> !(!mem_ld_n && mem_rw)); // R8

  AST_WR_AFTER_RD_GAP1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ld_n && !mem_rw) |-> !$past(!mem_ld_n && mem_rw)); // R9

  AST_WR_AFTER_RD_GAP2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ld_n && !mem_rw && !dll_off) |-> !$past(!mem_ld_n && mem_rw, 2)); // R9

endmodule

bind b2_sram_ctrl b2_sram_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dll_off     (dll_off),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .mem_ld_n    (mem_ld_n),
  .mem_rw      (mem_rw),
  .mem_wd_oe   (mem_wd_oe),
  .mem_qvld    (mem_qvld),
  .rsp_valid   (rsp_valid),
  .err_timeout (err_timeout),
  .rd_capture  (rd_capture),
  .rd_expire   (rd_expire)
);

// File: tb/b2_sram_ctrl_test.sv
`timescale 1ns/100ps
module b2_sram_ctrl_test;
  localparam int AW = 20;
  localparam int DW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dll_off = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata_lo = '0;
  logic [DW-1:0] req_wdata_hi = '0;
  logic          mem_ld_n, mem_rw, mem_wd_oe;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wd_lo, mem_wd_hi;
  logic          mem_qvld = 1'b0;
  logic [DW-1:0] mem_rd_lo = '0;
  logic [DW-1:0] mem_rd_hi = '0;
  logic          rsp_valid, err_timeout;
  logic [AW-1:0] rsp_addr;
  logic [DW-1:0] rsp_rdata_lo, rsp_rdata_hi;

  always #2 clk = ~clk;

  b2_sram_ctrl uut (.*);

  typedef struct { int due; logic [AW-1:0] a; bit drop; } rd_item_t;
  typedef struct { int due; logic [4:0] a; logic [DW-1:0] lo; logic [DW-1:0] hi; } wr_item_t;
  typedef struct { int cyc; logic [AW-1:0] a; logic [DW-1:0] lo; logic [DW-1:0] hi; } exp_t;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int spur_at = -1;
  int rsp_seen = 0;
  logic [DW-1:0] marr   [32];
  logic [DW-1:0] shadow [32];
  rd_item_t rdq[$];
  wr_item_t wq[$];
  exp_t     scq[$];
  bit       drop_q[$];
  rd_item_t rp;
  wr_item_t wp;
  exp_t     ep;
  bit       exp_oe;

  function automatic int lat_now();
    return dll_off ? 1 : 2;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  // memory model + scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    mem_qvld  = 1'b0;
    mem_rd_lo = '0;
    mem_rd_hi = '0;
    if (spur_at == cyc) begin
      mem_qvld  = 1'b1;
      mem_rd_lo = 18'h2A5A5;
      mem_rd_hi = 18'h15A5A;
    end
    if (rdq.size() > 0 && rdq[0].due == cyc) begin
      rp = rdq.pop_front();
      if (!rp.drop) begin
        mem_qvld  = 1'b1;
        mem_rd_lo = marr[rp.a[4:0]];
        mem_rd_hi = marr[rp.a[4:0] + 5'd1];
      end
    end
    #1;
    if (rst_n) begin
      exp_oe = (wq.size() > 0 && wq[0].due == cyc);
      if (exp_oe || mem_wd_oe) check(mem_wd_oe == exp_oe, "R3 drive enable", mem_wd_oe, exp_oe);
      if (exp_oe) begin
        wp = wq.pop_front();
        check(mem_wd_lo == wp.lo, "R3 low word", mem_wd_lo, wp.lo);
        check(mem_wd_hi == wp.hi, "R3 high word", mem_wd_hi, wp.hi);
        marr[wp.a]         = mem_wd_lo;
        marr[wp.a + 5'd1]  = mem_wd_hi;
      end
      if (!req_valid && !mem_ld_n) check(1'b0, "R2 nop strobe", mem_ld_n, 1);
      if (!mem_ld_n) begin
        check(mem_addr == req_addr, "R2 address", mem_addr, req_addr);
        check(mem_rw == !req_write, "R2 direction", mem_rw, !req_write);
        if (mem_rw) begin
          rp.due  = cyc + lat_now();
          rp.a    = mem_addr;
          rp.drop = (drop_q.size() > 0) ? drop_q.pop_front() : 1'b0;
          rdq.push_back(rp);
        end else begin
          wp.due = cyc + 1;
          wp.a   = mem_addr[4:0];
          wp.lo  = req_wdata_lo;
          wp.hi  = req_wdata_hi;
          wq.push_back(wp);
        end
      end
      if (rsp_valid) begin
        rsp_seen++;
        if (scq.size() == 0) begin
          check(1'b0, "R5 unexpected response", rsp_addr, 0);
        end else begin
          ep = scq.pop_front();
          check(cyc == ep.cyc, "R4 response cycle", cyc, ep.cyc);
          check(rsp_addr == ep.a, "R6 response address", rsp_addr, ep.a);
          check(rsp_rdata_lo == ep.lo, "R6 low word", rsp_rdata_lo, ep.lo);
          check(rsp_rdata_hi == ep.hi, "R6 high word", rsp_rdata_hi, ep.hi);
        end
      end
    end
  end

  // driver: call right after a falling edge; returns after the next one
  task automatic send(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] lo,
                      input logic [DW-1:0] hi, input bit drop, output int acc);
    logic [4:0] ix;
    ix = a[4:0];
    req_valid    = 1'b1;
    req_write    = wr;
    req_addr     = a;
    req_wdata_lo = lo;
    req_wdata_hi = hi;
    forever begin
      #0.5;
      if (req_ready) begin
        acc = cyc;
        if (wr) begin
          shadow[ix]        = lo;
          shadow[ix + 5'd1] = hi;
        end else begin
          drop_q.push_back(drop);
          if (!drop) begin
            ep.cyc = cyc + lat_now() + 1;
            ep.a   = a;
            ep.lo  = shadow[ix];
            ep.hi  = shadow[ix + 5'd1];
            scq.push_back(ep);
          end
        end
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int t0, t1, t2, t3, t4, seen0;
    for (int i = 0; i < 32; i++) begin
      marr[i]   = DW'(i * 7 + 3);
      shadow[i] = DW'(i * 7 + 3);
    end
    idle(3);
    #1;
    check(mem_ld_n == 1'b1, "R1 strobe idle", mem_ld_n, 1);
    check(mem_wd_oe == 1'b0, "R1 bus released", mem_wd_oe, 0);
    check(rsp_valid == 1'b0, "R1 no response", rsp_valid, 0);
    check(err_timeout == 1'b0, "R1 error clear", err_timeout, 0);
    check(req_ready == 1'b1, "R1 ready", req_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // normal latency: writes back to back, then read right after write
    send(1, 20'h00000, 18'h11111, 18'h12222, 0, t0);
    send(1, 20'h00002, 18'h13333, 18'h14444, 0, t1);
    send(1, 20'h00004, 18'h15555, 18'h16666, 0, t2);
    check(t1 - t0 == 1 && t2 - t1 == 1, "R10 write streak", t2 - t0, 2);
    send(1, 20'h00006, 18'h17777, 18'h18888, 0, t0);
    send(0, 20'h00006, 0, 0, 0, t1);
    check(t1 - t0 == 1, "R8 read after write normal", t1 - t0, 1);
    send(0, 20'h00000, 0, 0, 0, t0);
    send(0, 20'h00002, 0, 0, 0, t1);
    send(0, 20'h00004, 0, 0, 0, t2);
    check(t1 - t0 == 1 && t2 - t1 == 1, "R10 read streak", t2 - t0, 2);
    send(1, 20'h00008, 18'h21111, 18'h22222, 0, t3);
    check(t3 - t2 == 3, "R9 write after read normal", t3 - t2, 3);
    send(0, 20'h00008, 0, 0, 0, t0);
    idle(6);

    // one-cycle latency mode
    dll_off = 1'b1;
    send(1, 20'h0000A, 18'h31111, 18'h32222, 0, t0);
    send(0, 20'h0000A, 0, 0, 0, t1);
    check(t1 - t0 == 2, "R8 read after write dll off", t1 - t0, 2);
    send(1, 20'h0000C, 18'h33333, 18'h34444, 0, t2);
    check(t2 - t1 == 2, "R9 write after read dll off", t2 - t1, 2);
    send(0, 20'h0000C, 0, 0, 0, t0);
    send(0, 20'h00000, 0, 0, 0, t1);
    idle(6);
    dll_off = 1'b0;
    idle(2);

    // stray qualifier with nothing outstanding
    seen0 = rsp_seen;
    spur_at = cyc + 2;
    idle(5);
    check(rsp_seen == seen0, "R5 stray qualifier ignored", rsp_seen - seen0, 0);
    check(err_timeout == 1'b0, "R5 stray qualifier no error", err_timeout, 0);

    // missing qualifier
    send(0, 20'h00010, 0, 0, 1, t0);
    idle(6);
    check(err_timeout == 1'b1, "R7 timeout flag", err_timeout, 1);
    send(0, 20'h00002, 0, 0, 0, t0);
    idle(5);
    check(err_timeout == 1'b1, "R7 flag sticky", err_timeout, 1);

    // fill the tracker with unanswered reads
    send(0, 20'h00001, 0, 0, 1, t0);
    send(0, 20'h00003, 0, 0, 1, t1);
    send(0, 20'h00005, 0, 0, 1, t2);
    send(0, 20'h00007, 0, 0, 1, t3);
    send(0, 20'h00009, 0, 0, 1, t4);
    check(t4 - t0 == 5, "R11 read held while full", t4 - t0, 5);
    idle(12);
    check(scq.size() == 0, "R6 all responses returned", scq.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule